// File: doc/BRIEF.md
# Evaluation and Debug Mode Controller

This block decides which of two special operating modes a supply-management chip is in. Each mode changes how the rest of the chip supervises itself. The first is a debug mode in which the watchdog is switched off. The second is a forced-normal evaluation mode. In forced-normal mode the register interface is locked out, supervision and monitoring are switched off, the bus transceivers are kept on line and the inhibit outputs are held high. The block turns these decisions into enable and gating signals that the surrounding logic obeys.

There are two ways into debug mode. The first is the test-pin level captured at power-on. The second is a one-shot bit in a special register, written during the start-up state. Debug mode stays active only while every mode-register write carries the keep bit. A write without it ends the mode, and the mode cannot be entered again until the next power-on. Forced-normal mode is latched at power-on and has priority over debug mode. In that mode only a V1 undervoltage that lasts long enough can still ask for fail-safe. The controller times that condition in ticks.

Top module: `mode_ctrl_evdbg`

## Requirements
- R1: On the first clock edge after `por_n` rises, `fnm_on` takes `tp_fnm_lvl` and `dbg_on` takes `tp_dbg_lvl & ~tp_fnm_lvl`. After that edge the test-pin inputs have no effect. While `por_n` is low, `fnm_on=0`, `dbg_on=0`, `spi_block=1`, `wd_kick=0` and `fs_uv_req=0`.
- R2: While `fnm_on=1`, the following outputs are all 0: `wd_en`, `int_mon_en`, `rst_mon_en`, `rst_len_en` and `fs_path_en`. `spi_block` is 1, and register writes do not produce `wd_kick`. When both modes are off, all five enables are 1.
- R3: While `fnm_on=1`, the outputs are driven as follows. `trx_offline_ok` is 0. `inh_o` and `sysinh_o` are 1. `en_o` follows `rstn_lvl`. When `fnm_on=0`, these outputs pass through `trx_offline_req`, `inh_req`, `sysinh_req` and `en_req`.
- R4: A special-register write (`spc_wr`) with `wr_data[0]=1`, made while `startup_st=1` and the entry permission is still armed, sets `dbg_on` at that clock edge. While `dbg_on=1`, `wd_en=0`.
- R5: The entry permission is armed by power-on. It is used up by a successful entry. It is also lost for good at any edge that sees `startup_st=0`. Once it is gone, special-register writes leave `dbg_on` at 0.
- R6: Every accepted mode-register write (`mode_wr` while `spi_block=0`) gives a one-cycle `wd_kick` after the edge. If `dbg_on=1`, a write with `wr_data[1]=0` clears `dbg_on` at that edge, and a write with `wr_data[1]=1` keeps it set.
- R7: Once debug mode has been left, neither a special-register write nor anything else sets `dbg_on` again until the next power-on reset.
- R8: While `fnm_on=1`, a V1 undervoltage that stays asserted for `UV_TICKS` ticks gives exactly one one-cycle `fs_uv_req` pulse, after the edge of the last of those ticks. If `v1_uv` falls earlier, the tick count restarts from zero and no pulse is given.
- R9: When the test pins ask for both modes at power-on, only forced-normal mode is entered. In forced-normal mode, special-register writes cannot start debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| startup_st | input | 1 | Chip is in its start-up state |
| tp_fnm_lvl | input | 1 | Test pin qualified for forced-normal mode |
| tp_dbg_lvl | input | 1 | Test pin qualified for debug mode |
| spc_wr | input | 1 | Special-register write strobe |
| mode_wr | input | 1 | Mode-register write strobe |
| wr_data | input | DW | Write data (bit 0 entry request, bit 1 keep-debug) |
| v1_uv | input | 1 | V1 undervoltage flag |
| tick | input | 1 | Timebase tick for the undervoltage timer |
| rstn_lvl | input | 1 | Current level of the reset output |
| en_req | input | 1 | Enable output request in normal operation |
| inh_req | input | 1 | Inhibit/limp output request in normal operation |
| sysinh_req | input | 1 | System-inhibit output request in normal operation |
| trx_offline_req | input | 1 | Request to put the transceivers off line |
| fnm_on | output | 1 | Forced-normal mode active |
| dbg_on | output | 1 | Debug mode active |
| spi_block | output | 1 | Register access is blocked |
| wd_en | output | 1 | Watchdog supervision enable |
| wd_kick | output | 1 | Watchdog trigger pulse |
| int_mon_en | output | 1 | Interrupt monitoring enable |
| rst_mon_en | output | 1 | Reset monitoring enable |
| rst_len_en | output | 1 | Reset lengthening enable |
| fs_path_en | output | 1 | Ordinary fail-safe entry paths enabled |
| fs_uv_req | output | 1 | Fail-safe request from a long V1 undervoltage |
| trx_offline_ok | output | 1 | Transceivers may go off line |
| inh_o | output | 1 | Inhibit/limp output |
| sysinh_o | output | 1 | System-inhibit output |
| en_o | output | 1 | Enable output |

## Verification
The undervoltage timer can reach its last tick in the same cycle that V1 recovers. The recovery must win, so the timer clears and gives no fail-safe pulse. The bench holds the undervoltage for one tick fewer than the threshold and drops `v1_uv` just before the edge that would have expired the timer. It then checks that `fs_uv_req` stays low. A further run, held for the full threshold, shows the single pulse on the expected cycle.

// File: rtl/mode_ctrl_evdbg.sv
module mode_ctrl_evdbg #(
  parameter int DW       = 8,
  parameter int SPC_BIT  = 0,
  parameter int MODE_BIT = 1,
  parameter int UV_TICKS = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          startup_st,
  input  logic          tp_fnm_lvl,
  input  logic          tp_dbg_lvl,
  input  logic          spc_wr,
  input  logic          mode_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          v1_uv,
  input  logic          tick,
  input  logic          rstn_lvl,
  input  logic          en_req,
  input  logic          inh_req,
  input  logic          sysinh_req,
  input  logic          trx_offline_req,
  output logic          fnm_on,
  output logic          dbg_on,
  output logic          spi_block,
  output logic          wd_en,
  output logic          wd_kick,
  output logic          int_mon_en,
  output logic          rst_mon_en,
  output logic          rst_len_en,
  output logic          fs_path_en,
  output logic          fs_uv_req,
  output logic          trx_offline_ok,
  output logic          inh_o,
  output logic          sysinh_o,
  output logic          en_o
);
  localparam int CW = $clog2(UV_TICKS + 1);

  logic          init_pend, fnm_q, dbg_q, dbg_spent, arm_q, kick_q;
  logic          uv_done, fs_q;
  logic [CW-1:0] uv_cnt;

  wire spi_ok   = !fnm_q && !init_pend;
  wire mode_hit = mode_wr && spi_ok;
  wire spc_hit  = spc_wr && spi_ok && wr_data[SPC_BIT] && arm_q && startup_st && !dbg_spent;
  wire dbg_exit = mode_hit && dbg_q && !wr_data[MODE_BIT];
  wire uv_last  = fnm_q && v1_uv && tick && !uv_done && (uv_cnt == CW'(UV_TICKS - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      init_pend <= 1'b1;
      fnm_q     <= 1'b0;
      dbg_q     <= 1'b0;
      dbg_spent <= 1'b0;
      arm_q     <= 1'b1;
      kick_q    <= 1'b0;
    end else begin
      kick_q <= mode_hit;
      if (init_pend) begin
        init_pend <= 1'b0;
        fnm_q     <= tp_fnm_lvl;
        dbg_q     <= tp_dbg_lvl && !tp_fnm_lvl;
        if (tp_fnm_lvl) arm_q <= 1'b0;
      end else begin
        if (dbg_exit) begin
          dbg_q     <= 1'b0;
          dbg_spent <= 1'b1;
        end else if (spc_hit) begin
          dbg_q <= 1'b1;
        end
        if (spc_hit || !startup_st) arm_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      uv_cnt  <= '0;
      uv_done <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      fs_q <= uv_last;
      if (!fnm_q || !v1_uv) begin
        uv_cnt  <= '0;
        uv_done <= 1'b0;
      end else if (tick && !uv_done) begin
        uv_cnt <= uv_cnt + 1'b1;
        if (uv_last) uv_done <= 1'b1;
      end
    end
  end

  assign fnm_on         = fnm_q;
  assign dbg_on         = dbg_q;
  assign spi_block      = !spi_ok;
  assign wd_en          = !fnm_q && !dbg_q;
  assign wd_kick        = kick_q;
  assign int_mon_en     = !fnm_q;
  assign rst_mon_en     = !fnm_q;
  assign rst_len_en     = !fnm_q;
  assign fs_path_en     = !fnm_q;
  assign fs_uv_req      = fs_q;
  assign trx_offline_ok = trx_offline_req && !fnm_q;
  assign inh_o          = inh_req || fnm_q;
  assign sysinh_o       = sysinh_req || fnm_q;
  assign en_o           = fnm_q ? rstn_lvl : en_req;

  p_fnm_frozen_r1: assert property (@(posedge clk) disable iff (!por_n)
    !init_pend |=> $stable(fnm_q));

  p_kick_src_r6: assert property (@(posedge clk) disable iff (!por_n)
    kick_q |-> $past(mode_wr) && !$past(fnm_q) && !$past(init_pend));

  p_entry_src_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(dbg_q) && !$past(init_pend) |-> $past(spc_wr) && $past(startup_st));

  p_no_reentry_r7: assert property (@(posedge clk) disable iff (!por_n)
    dbg_spent && !dbg_q |=> !dbg_q);

  p_fnm_excl_r9: assert property (@(posedge clk) disable iff (!por_n)
    fnm_q |-> !dbg_q);

  p_uv_single_r8: assert property (@(posedge clk) disable iff (!por_n)
    fs_q |=> !fs_q);

  p_uv_only_fnm_r8: assert property (@(posedge clk) disable iff (!por_n)
    fs_q |-> $past(fnm_q) && $past(v1_uv));
endmodule

// File: tb/test_mode_ctrl_evdbg.sv
module test_mode_ctrl_evdbg;
  localparam int CLK_PERIOD = 10;
  localparam int UVT = 8;

  logic clk = 1'b0;
  logic por_n, startup_st, tp_fnm_lvl, tp_dbg_lvl, spc_wr, mode_wr;
  logic [7:0] wr_data;
  logic v1_uv, tick, rstn_lvl, en_req, inh_req, sysinh_req, trx_offline_req;
  logic fnm_on, dbg_on, spi_block, wd_en, wd_kick, int_mon_en, rst_mon_en;
  logic rst_len_en, fs_path_en, fs_uv_req, trx_offline_ok, inh_o, sysinh_o, en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_ctrl_evdbg #(.DW(8), .SPC_BIT(0), .MODE_BIT(1), .UV_TICKS(UVT)) i_mode_ctrl_evdbg (
    .clk(clk), .por_n(por_n), .startup_st(startup_st), .tp_fnm_lvl(tp_fnm_lvl),
    .tp_dbg_lvl(tp_dbg_lvl), .spc_wr(spc_wr), .mode_wr(mode_wr), .wr_data(wr_data),
    .v1_uv(v1_uv), .tick(tick), .rstn_lvl(rstn_lvl), .en_req(en_req), .inh_req(inh_req),
    .sysinh_req(sysinh_req), .trx_offline_req(trx_offline_req), .fnm_on(fnm_on),
    .dbg_on(dbg_on), .spi_block(spi_block), .wd_en(wd_en), .wd_kick(wd_kick),
    .int_mon_en(int_mon_en), .rst_mon_en(rst_mon_en), .rst_len_en(rst_len_en),
    .fs_path_en(fs_path_en), .fs_uv_req(fs_uv_req), .trx_offline_ok(trx_offline_ok),
    .inh_o(inh_o), .sysinh_o(sysinh_o), .en_o(en_o));

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_por(input logic f, input logic d);
    @(negedge clk);
    por_n = 1'b0; tp_fnm_lvl = f; tp_dbg_lvl = d; startup_st = 1'b1;
    spc_wr = 0; mode_wr = 0; wr_data = '0; v1_uv = 0; tick = 0;
    rstn_lvl = 0; en_req = 0; inh_req = 0; sysinh_req = 0; trx_offline_req = 0;
    step(); step();
    por_n = 1'b1;
    step();
    tp_fnm_lvl = ~f; tp_dbg_lvl = ~d;
  endtask

  task automatic wr_spc(input logic b0);
    spc_wr = 1'b1; wr_data = {6'b0, 1'b0, b0};
    step();
    spc_wr = 1'b0; wr_data = '0;
  endtask

  task automatic wr_mode(input logic b1);
    mode_wr = 1'b1; wr_data = {6'b0, b1, 1'b0};
    step();
    mode_wr = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    por_n = 1'b0; tp_fnm_lvl = 1; tp_dbg_lvl = 1;
    step();
    chk(fnm_on, 0, "R1", "fnm_on in reset");
    chk(dbg_on, 0, "R1", "dbg_on in reset");
    chk(spi_block, 1, "R1", "spi_block in reset");
    chk(wd_kick, 0, "R1", "wd_kick in reset");
    chk(fs_uv_req, 0, "R1", "fs_uv_req in reset");
    do_por(1'b0, 1'b0);
    chk(fnm_on, 0, "R1", "fnm_on from pin low");
    chk(dbg_on, 0, "R1", "dbg_on from pin low");
    step(); step();
    chk(fnm_on, 0, "R1", "late pin change ignored (fnm)");
    chk(dbg_on, 0, "R1", "late pin change ignored (dbg)");
    chk(wd_en, 1, "R2", "wd_en in plain mode");
    chk(int_mon_en & rst_mon_en & rst_len_en & fs_path_en, 1, "R2", "enables in plain mode");
    trx_offline_req = 1; inh_req = 0; sysinh_req = 1; en_req = 1; rstn_lvl = 0; #1;
    chk(trx_offline_ok, 1, "R3", "offline passthrough");
    chk(inh_o, 0, "R3", "inh passthrough");
    chk(sysinh_o, 1, "R3", "sysinh passthrough");
    chk(en_o, 1, "R3", "en passthrough");
  endtask

  task automatic t_fnm();
    do_por(1'b1, 1'b1);
    chk(fnm_on, 1, "R9", "fnm wins when both pins set");
    chk(dbg_on, 0, "R9", "dbg off when both pins set");
    chk(spi_block, 1, "R2", "spi blocked in fnm");
    chk(wd_en | int_mon_en | rst_mon_en | rst_len_en | fs_path_en, 0, "R2", "enables off in fnm");
    wr_mode(1'b0);
    chk(wd_kick, 0, "R2", "no kick in fnm");
    wr_spc(1'b1);
    chk(dbg_on, 0, "R9", "special write ignored in fnm");
    trx_offline_req = 1; inh_req = 0; sysinh_req = 0; en_req = 0; rstn_lvl = 1; #1;
    chk(trx_offline_ok, 0, "R3", "offline blocked in fnm");
    chk(inh_o, 1, "R3", "inh high in fnm");
    chk(sysinh_o, 1, "R3", "sysinh high in fnm");
    chk(en_o, 1, "R3", "en follows rstn high");
    rstn_lvl = 0; en_req = 1; #1;
    chk(en_o, 0, "R3", "en follows rstn low");
  endtask

  task automatic t_dbg_pin();
    do_por(1'b0, 1'b1);
    chk(dbg_on, 1, "R1", "dbg from pin");
    chk(wd_en, 0, "R4", "watchdog off in dbg");
    wr_mode(1'b1);
    chk(wd_kick, 1, "R6", "kick on mode write");
    chk(dbg_on, 1, "R6", "keep bit holds dbg");
    step();
    chk(wd_kick, 0, "R6", "kick lasts one cycle");
    wr_mode(1'b0);
    chk(dbg_on, 0, "R6", "clear bit exits dbg");
    wr_spc(1'b1);
    chk(dbg_on, 0, "R7", "no reentry after pin entry");
  endtask

  task automatic t_dbg_reg();
    do_por(1'b0, 1'b0);
    wr_spc(1'b0);
    chk(dbg_on, 0, "R4", "entry bit clear ignored");
    wr_spc(1'b1);
    chk(dbg_on, 1, "R4", "register entry");
    chk(wd_en, 0, "R4", "watchdog off after register entry");
    wr_mode(1'b0);
    chk(dbg_on, 0, "R6", "exit after register entry");
    wr_spc(1'b1);
    chk(dbg_on, 0, "R7", "no reentry via register");
    wr_mode(1'b1);
    chk(dbg_on, 0, "R7", "keep bit does not reenter");
    do_por(1'b0, 1'b0);
    wr_spc(1'b1);
    chk(dbg_on, 1, "R7", "power-on rearms entry");
  endtask

  task automatic t_arm_lost();
    do_por(1'b0, 1'b0);
    startup_st = 1'b0;
    step();
    startup_st = 1'b1;
    wr_spc(1'b1);
    chk(dbg_on, 0, "R5", "permission lost after startup left");
  endtask

  task automatic t_uv();
    int hits;
    int at;
    do_por(1'b1, 1'b0);
    v1_uv = 1; tick = 1;
    hits = 0; at = 0;
    for (int i = 1; i <= 20; i++) begin
      step();
      if (fs_uv_req) begin hits++; at = i; end
    end
    chk(hits == 1, 1, "R8", "single pulse on long uv");
    chk(at == UVT, 1, "R8", "pulse cycle");
    v1_uv = 0; step();
    v1_uv = 1; hits = 0;
    for (int i = 1; i <= UVT - 1; i++) begin
      step();
      if (fs_uv_req) hits++;
    end
    v1_uv = 0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (fs_uv_req) hits++;
    end
    chk(hits == 0, 1, "R8", "recovery on last tick cancels");
    v1_uv = 1;
    for (int i = 1; i <= UVT - 1; i++) begin
      step();
      if (fs_uv_req) hits++;
    end
    chk(hits == 0, 1, "R8", "count restarted after recovery");
    chk(fnm_on, 1, "R8", "stays in fnm");
    v1_uv = 0; tick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    por_n = 0; startup_st = 1; tp_fnm_lvl = 0; tp_dbg_lvl = 0; spc_wr = 0; mode_wr = 0;
    wr_data = '0; v1_uv = 0; tick = 0; rstn_lvl = 0; en_req = 0; inh_req = 0;
    sysinh_req = 0; trx_offline_req = 0;
    t_reset();
    t_fnm();
    t_dbg_pin();
    t_dbg_reg();
    t_arm_lost();
    t_uv();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule